// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a small sum-of-products programmable logic device. Its data input is the OR of a group of product-term lines from the AND array. Configuration inputs decide whether that sum reaches the pin directly or through a D flip-flop, whether the pin carries the true or the inverted value, which of several clock lines drives the flip-flop, and which edge of that line is active. With two choices for storage and two for polarity, the cell has four output configurations.

Three more product-term lines control the cell. One presets the flip-flop on the next active edge. One clears it at once, with no edge needed. One enables the output driver. The pin is modelled as a driver value, a driver enable and the level seen on the wire, and an external value takes over the wire when the driver is off. A feedback bit goes back to the array. In registered mode it comes from the flip-flop. In combinational mode it comes from the pin level.

Top module: `mcell_top`

## Requirements
- R1: The cell's sum equals the OR of all `pt_sum` bits. In combinational mode (`cfg_registered`=0) with the driver enabled, `pin_level` and `fb` equal that sum XOR `cfg_invert` at once.
- R2: In registered mode (`cfg_registered`=1) the flip-flop loads the sum only on an active edge. The sum is not seen at `fb` before that edge.
- R3: The active edge is a rising edge of `clk_src[cfg_clk_sel]` when `cfg_clk_inv`=0, and a falling edge of it when `cfg_clk_inv`=1. Edges on other clock lines, and the opposite edge of the selected line, leave the flip-flop unchanged.
- R4: `pt_preset`=1 sets the flip-flop to 1 at the next active edge and has no effect before that edge.
- R5: `pt_clear`=1 forces the flip-flop to 0 at once, with no edge, and keeps it at 0 across active edges while it is held.
- R6: When `pt_clear` and `pt_preset` are both 1 at an active edge, the flip-flop is 0.
- R7: `rst_n`=0 sets the flip-flop to 0 at the next active edge and has no effect before that edge.
- R8: With `pt_oe`=0, `pin_oe` is 0 and `pin_level` equals `pin_ext`, while `pin_drive` still carries the cell's output value. With `pt_oe`=1, `pin_level` equals `pin_drive`.
- R9: In registered mode `fb` equals the flip-flop (true polarity), whatever `pin_ext`, `pt_oe` and `cfg_invert` are.
- R10: In combinational mode `fb` equals `pin_level`, so with the driver off it follows `pin_ext`.
- R11: In registered mode `pin_drive` equals the flip-flop XOR `cfg_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | NUM_CLK | Candidate clock lines |
| rst_n | input | 1 | Active-low reset, sampled on the active edge |
| cfg_registered | input | 1 | 1 = registered output, 0 = combinational |
| cfg_invert | input | 1 | 1 = inverted output polarity |
| cfg_clk_sel | input | SEL_W | Index of the clock line used |
| cfg_clk_inv | input | 1 | 1 = falling edge is active |
| pt_sum | input | NUM_PT | Product terms ORed into the data sum |
| pt_preset | input | 1 | Synchronous preset term |
| pt_clear | input | 1 | Asynchronous clear term |
| pt_oe | input | 1 | Output-enable term |
| pin_ext | input | 1 | Value seen on the wire when not driven |
| pin_drive | output | 1 | Value offered by the output driver |
| pin_oe | output | 1 | Output driver enable |
| pin_level | output | 1 | Resolved wire level |
| fb | output | 1 | Feedback bit to the AND array |

## Verification
Two pairs of functions can act in the same cycle: preset with clear, and clear with data capture. The bench drives preset and clear high together across an active edge and expects 0. It also raises clear in the middle of a cycle while the sum is 1, then checks that `fb` drops before any edge and stays 0 across an edge while clear is held. For each clock source and edge choice, a stray edge on the other line and the opposite edge on the selected line are applied between real edges, and `fb` must not move.

// File: rtl/mcell_pkg.sv
// Package: types shared by the macrocell modules.
// Assumes: the output configuration is fully described by two bits.
package mcell_pkg;

    // Output configuration: {registered, invert}
    typedef enum logic [1:0] {
        OUT_COMB_TRUE = 2'b00,
        OUT_COMB_INV  = 2'b01,
        OUT_REG_TRUE  = 2'b10,
        OUT_REG_INV   = 2'b11
    } out_mode_e;

    // Packs the two configuration bits into an output mode.
    function automatic out_mode_e make_mode(input logic registered, input logic invert);
        return out_mode_e'({registered, invert});
    endfunction

endpackage

// File: rtl/mcell_sop.sv
// Module: mcell_sop
// Purpose: ORs the product-term lines of one cell into a single sum bit.
// Assumes: NUM_PT >= 1. A product term is already a resolved AND-array output.
module mcell_sop #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pt,
    output logic              sum
);

    logic [NUM_PT:0] chain;

    // Start the OR chain from zero.
    assign chain[0] = 1'b0;

    // One OR stage per product term.
    for (genvar i = 0; i < NUM_PT; i++) begin : g_or
        assign chain[i+1] = chain[i] | pt[i];
    end

    assign sum = chain[NUM_PT];

endmodule

// File: rtl/mcell_reg.sv
// Module: mcell_reg
// Purpose: clock selection and polarity for the cell's storage element, plus a
//          D flip-flop with async clear, sync reset and sync preset.
// Assumes: configuration changes happen only while rst_n is low. A change may
//          make a spurious edge, which the reset then overrides.
module mcell_reg #(
    parameter int NUM_CLK = 2,
    parameter int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] clk_src,
    input  logic [SEL_W-1:0]   clk_sel,
    input  logic               clk_inv,
    input  logic               rst_n,
    input  logic               d,
    input  logic               preset,
    input  logic               clear,
    output logic               q,
    output logic               gclk
);

    // Pick the clock line and move the active edge to a rising edge.
    assign gclk = clk_src[clk_sel] ^ clk_inv;

    // Storage: clear acts at once; reset beats preset, preset beats data.
    always_ff @(posedge gclk or posedge clear) begin
        if (clear)       q <= 1'b0;
        else if (!rst_n) q <= 1'b0;
        else if (preset) q <= 1'b1;
        else             q <= d;
    end

    // R5: while clear is sampled high, the register reads 0.
    assert_clear_holds_R5: assert property (@(posedge gclk) disable iff (!rst_n)
        clear |-> (q == 1'b0))
        else $error("R5 clear did not hold register at 0");

    // R4: a preset seen at an edge (without clear) gives 1 after that edge.
    assert_preset_sets_R4: assert property (@(posedge gclk) disable iff (!rst_n || clear)
        (preset && !clear) |=> (q == 1'b1))
        else $error("R4 preset did not set register");

    // R6: preset and clear together leave the register at 0.
    assert_clear_wins_R6: assert property (@(posedge gclk) disable iff (!rst_n)
        (preset && clear) |=> (q == 1'b0))
        else $error("R6 clear did not win over preset");

    // R2: with no control term active, the edge captures the sum.
    assert_capture_R2: assert property (@(posedge gclk) disable iff (!rst_n || clear)
        (!preset && !clear) |=> (q == $past(d)))
        else $error("R2 register did not capture data");

endmodule

// File: rtl/mcell_out.sv
// Module: mcell_out
// Purpose: output polarity, registered/combinational selection, tri-state pin
//          model and feedback selection for one cell.
// Assumes: the pin is modelled as driver value, driver enable and a resolved
//          level; the external value wins when the driver is off.
module mcell_out
    import mcell_pkg::*;
(
    input  logic      gclk,
    input  logic      rst_n,
    input  out_mode_e mode,
    input  logic      sum,
    input  logic      q,
    input  logic      oe,
    input  logic      pin_ext,
    output logic      pin_drive,
    output logic      pin_oe,
    output logic      pin_level,
    output logic      fb
);

    // Driver value for each of the four output configurations.
    always_comb begin
        case (mode)
            OUT_COMB_TRUE: pin_drive = sum;
            OUT_COMB_INV:  pin_drive = ~sum;
            OUT_REG_TRUE:  pin_drive = q;
            OUT_REG_INV:   pin_drive = ~q;
            default:       pin_drive = sum;
        endcase
    end

    // Enable the driver from the cell's own output-enable term.
    assign pin_oe = oe;

    // Resolve the wire: driven value or the external value.
    assign pin_level = pin_oe ? pin_drive : pin_ext;

    // Feedback: register in registered modes, pin level otherwise.
    always_comb begin
        case (mode)
            OUT_REG_TRUE, OUT_REG_INV: fb = q;
            default:                   fb = pin_level;
        endcase
    end

    // R9: registered feedback tracks the flip-flop.
    assert_fb_reg_R9: assert property (@(posedge gclk) disable iff (!rst_n)
        mode[1] |-> (fb == q))
        else $error("R9 registered feedback differs from register");

    // R10: combinational feedback equals the wire level.
    assert_fb_comb_R10: assert property (@(posedge gclk) disable iff (!rst_n)
        !mode[1] |-> (fb == pin_level))
        else $error("R10 combinational feedback differs from pin");

    // R8: an undriven wire shows the external value.
    assert_hiz_R8: assert property (@(posedge gclk) disable iff (!rst_n)
        !oe |-> (pin_level == pin_ext))
        else $error("R8 undriven pin not at external value");

    // R11: registered driver is the register with the chosen polarity.
    assert_reg_pol_R11: assert property (@(posedge gclk) disable iff (!rst_n)
        mode[1] |-> (pin_drive == (q ^ mode[0])))
        else $error("R11 registered polarity wrong");

endmodule

// File: rtl/mcell_top.sv
// Module: mcell_top
// Purpose: one output macrocell. Sums the product terms, stores or passes the
//          sum, applies polarity, drives the pin model and returns feedback.
// Assumes: configuration is static except while rst_n is held low.
module mcell_top
    import mcell_pkg::*;
#(
    parameter int NUM_PT  = 8,
    parameter int NUM_CLK = 2,
    parameter int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] clk_src,
    input  logic               rst_n,
    input  logic               cfg_registered,
    input  logic               cfg_invert,
    input  logic [SEL_W-1:0]   cfg_clk_sel,
    input  logic               cfg_clk_inv,
    input  logic [NUM_PT-1:0]  pt_sum,
    input  logic               pt_preset,
    input  logic               pt_clear,
    input  logic               pt_oe,
    input  logic               pin_ext,
    output logic               pin_drive,
    output logic               pin_oe,
    output logic               pin_level,
    output logic               fb
);

    logic      sum;
    logic      q;
    logic      gclk;
    out_mode_e mode;

    // Form the output mode from the two configuration bits.
    assign mode = make_mode(cfg_registered, cfg_invert);

    mcell_sop #(.NUM_PT(NUM_PT)) sop_i (
        .pt  (pt_sum),
        .sum (sum)
    );

    mcell_reg #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) reg_i (
        .clk_src (clk_src),
        .clk_sel (cfg_clk_sel),
        .clk_inv (cfg_clk_inv),
        .rst_n   (rst_n),
        .d       (sum),
        .preset  (pt_preset),
        .clear   (pt_clear),
        .q       (q),
        .gclk    (gclk)
    );

    mcell_out out_i (
        .gclk      (gclk),
        .rst_n     (rst_n),
        .mode      (mode),
        .sum       (sum),
        .q         (q),
        .oe        (pt_oe),
        .pin_ext   (pin_ext),
        .pin_drive (pin_drive),
        .pin_oe    (pin_oe),
        .pin_level (pin_level),
        .fb        (fb)
    );

endmodule

// File: tb/mcell_top_tb.sv
// Bench: sweeps clock source, edge, polarity and all product-term patterns of
// a small cell, with expected values worked out from the requirements.
module mcell_top_tb_top;

    localparam int CLK_P = 10;
    localparam int HALF  = CLK_P / 2;
    localparam int NPT   = 4;
    localparam int NCLK  = 2;
    localparam int SW    = 1;
    localparam int WD_LIMIT = 100000;

    logic [NCLK-1:0] clk_src = '0;
    logic            rst_n = 1'b0;
    logic            cfg_registered = 1'b0;
    logic            cfg_invert = 1'b0;
    logic [SW-1:0]   cfg_clk_sel = '0;
    logic            cfg_clk_inv = 1'b0;
    logic [NPT-1:0]  pt_sum = '0;
    logic            pt_preset = 1'b0;
    logic            pt_clear = 1'b0;
    logic            pt_oe = 1'b1;
    logic            pin_ext = 1'b0;
    logic            pin_drive, pin_oe, pin_level, fb;

    logic bclk = 1'b0;
    int   n_chk = 0;
    int   n_err = 0;
    int   wd_cnt = 0;
    bit   done = 1'b0;

    mcell_top #(.NUM_PT(NPT), .NUM_CLK(NCLK), .SEL_W(SW)) dut_i (
        .clk_src        (clk_src),
        .rst_n          (rst_n),
        .cfg_registered (cfg_registered),
        .cfg_invert     (cfg_invert),
        .cfg_clk_sel    (cfg_clk_sel),
        .cfg_clk_inv    (cfg_clk_inv),
        .pt_sum         (pt_sum),
        .pt_preset      (pt_preset),
        .pt_clear       (pt_clear),
        .pt_oe          (pt_oe),
        .pin_ext        (pin_ext),
        .pin_drive      (pin_drive),
        .pin_oe         (pin_oe),
        .pin_level      (pin_level),
        .fb             (fb)
    );

    // Bench clock for the watchdog.
    always #(HALF) bclk = ~bclk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge bclk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > WD_LIMIT && !done) begin
            done = 1'b1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", wd_cnt, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One active edge on the selected line (flips the line twice if needed).
    task automatic fire();
        int s = int'(cfg_clk_sel);
        if ((clk_src[s] ^ cfg_clk_inv) == 1'b1) begin
            clk_src[s] = ~clk_src[s];
            #(HALF);
        end
        clk_src[s] = ~clk_src[s];
        #(HALF);
    endtask

    // Both edges on the line that is not selected.
    task automatic toggle_other();
        int o = 1 - int'(cfg_clk_sel);
        clk_src[o] = ~clk_src[o];
        #(HALF);
        clk_src[o] = ~clk_src[o];
        #(HALF);
    endtask

    // Inactive edge on the selected line (called right after fire()).
    task automatic inactive_edge();
        int s = int'(cfg_clk_sel);
        clk_src[s] = ~clk_src[s];
        #(HALF);
    endtask

    // Apply a configuration under reset, leaving the register at 0.
    task automatic configure(input logic rg, input logic inv, input int sel, input logic cinv);
        rst_n = 1'b0;
        #(HALF);
        cfg_registered = rg;
        cfg_invert     = inv;
        cfg_clk_sel    = SW'(sel);
        cfg_clk_inv    = cinv;
        #(HALF);
        fire();
        rst_n = 1'b1;
        #(HALF);
    endtask

    initial begin
        // Reset state (R7): after an edge under reset the register reads 0.
        configure(1'b1, 1'b0, 0, 1'b0);
        check("R7 reset state fb", fb, 1'b0);
        check("R8 reset state pin_oe", pin_oe, 1'b1);

        // R1: combinational sweep over every pattern and both polarities.
        for (int inv = 0; inv < 2; inv++) begin
            configure(1'b0, inv[0], 0, 1'b0);
            pt_oe = 1'b1;
            for (int v = 0; v < (1 << NPT); v++) begin
                pt_sum = NPT'(v);
                #1;
                check("R1 comb pin_level", pin_level, (v != 0) ^ inv[0]);
                check("R10 comb fb", fb, (v != 0) ^ inv[0]);
            end
        end

        // R2/R3/R11/R9: registered sweep over source, edge and polarity.
        for (int sel = 0; sel < 2; sel++) begin
            for (int cinv = 0; cinv < 2; cinv++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    configure(1'b1, inv[0], sel, cinv[0]);
                    for (int v = 0; v < (1 << NPT); v++) begin
                        logic prev;
                        logic expv;
                        prev = fb;
                        pt_sum = NPT'(v);
                        expv = (v != 0);
                        #1;
                        check("R2 no load before edge", fb, prev);
                        fire();
                        check("R2 load on active edge", fb, expv);
                        check("R11 registered polarity", pin_drive, expv ^ inv[0]);
                        check("R9 registered fb true polarity", fb, expv);
                        pt_sum = expv ? '0 : '1;
                        toggle_other();
                        check("R3 other source ignored", fb, expv);
                        inactive_edge();
                        check("R3 inactive edge ignored", fb, expv);
                    end
                end
            end
        end

        // R4: preset waits for the edge.
        configure(1'b1, 1'b0, 0, 1'b0);
        pt_sum = '0;
        pt_preset = 1'b1;
        #1;
        check("R4 preset no effect before edge", fb, 1'b0);
        fire();
        check("R4 preset sets on edge", fb, 1'b1);
        pt_preset = 1'b0;
        fire();
        check("R4 data after preset released", fb, 1'b0);

        // R5: clear acts without an edge and holds across edges.
        pt_sum = '1;
        fire();
        check("R5 setup register at 1", fb, 1'b1);
        pt_clear = 1'b1;
        #1;
        check("R5 clear immediate", fb, 1'b0);
        fire();
        check("R5 clear held across edge", fb, 1'b0);
        pt_clear = 1'b0;
        #1;
        check("R5 stays 0 after release", fb, 1'b0);
        fire();
        check("R5 reload after clear", fb, 1'b1);

        // R6: clear wins over preset at the same edge.
        pt_sum = '0;
        fire();
        pt_preset = 1'b1;
        pt_clear  = 1'b1;
        fire();
        check("R6 clear beats preset", fb, 1'b0);
        pt_preset = 1'b0;
        pt_clear  = 1'b0;
        #1;

        // R7: reset waits for the edge.
        pt_sum = '1;
        fire();
        rst_n = 1'b0;
        #1;
        check("R7 reset no effect before edge", fb, 1'b1);
        fire();
        check("R7 reset clears on edge", fb, 1'b0);
        rst_n = 1'b1;
        fire();
        check("R7 load after reset", fb, 1'b1);

        // R8/R9: driver off in registered mode (register holds 1).
        pt_oe = 1'b0;
        pin_ext = 1'b0;
        #1;
        check("R8 pin_oe low", pin_oe, 1'b0);
        check("R8 level is external 0", pin_level, 1'b0);
        check("R8 drive still valid", pin_drive, 1'b1);
        check("R9 fb from register with pin off", fb, 1'b1);
        pin_ext = 1'b1;
        #1;
        check("R8 level is external 1", pin_level, 1'b1);
        pin_ext = 1'b0;
        #1;
        check("R9 fb ignores external value", fb, 1'b1);

        // R10: combinational feedback follows the wire.
        configure(1'b0, 1'b0, 0, 1'b0);
        pt_sum = '1;
        pt_oe = 1'b0;
        pin_ext = 1'b0;
        #1;
        check("R10 fb from external 0", fb, 1'b0);
        pin_ext = 1'b1;
        pt_sum = '0;
        #1;
        check("R10 fb from external 1", fb, 1'b1);
        pt_oe = 1'b1;
        #1;
        check("R8 level follows driver", pin_level, 1'b0);
        check("R10 fb from driver", fb, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule